// File: doc/BRIEF.md
# Prescaled Multi-Mode Timer Core

A 32-bit timer counter with a programmable clock divider in front of it. Whenever the timer is enabled, a prescaler produces one step tick every `presc_i + 1` clocks, and the counter moves once on each tick. A 2-bit mode code chooses how it moves: up from 0 to the reload value, down from the reload value to 0, or up/down between 0 and the reload value, reversing at each end. A mode bit chooses between periodic operation, where the count wraps or reverses without end, and one-shot operation, where the count stops at its terminal value and waits for a software restart.

Each step that moves the counter can raise single-cycle strobes: the count reached zero, it reached the reload value, it reached compare X, it reached compare Y, and a timeout. The strobes are registered together with the count, so in the strobe cycle `count_o` already holds the matching value and `down_o` shows the direction of that step. Logic further down, such as PWM generation or interrupt flags, uses these strobes. Compare strobes and direction together tell a rising-edge match from a falling-edge match.

Top module: `tmr_core`

## Requirements
- R1: While `en_i` is high and `presc_i` is held at P, the counter steps once every P+1 clocks. The first step comes P+1 clocks after enable or after a restart.
- R2: While `en_i` is low, the prescaler phase is cleared, `count_o` and `down_o` hold, and no strobe fires. The one exception is a restart.
- R3: Mode code 2'b10 (up): each step adds one. A step from a count at or above the reload value goes to 0. `down_o` reads 0.
- R4: Mode code 2'b01 (down): each step subtracts one. A step from 0 loads the reload value. `down_o` reads 1.
- R5: Mode code 2'b11 (up/down): the counter climbs from 0 to the reload value, then descends to 0, and repeats. The step after an endpoint moves away from it, so neither endpoint appears twice in a row. The exception is a reload value of 0, where the count stays 0. `down_o` is 1 for a count reached by a descending step.
- R6: With `periodic_i` low (one-shot), the counter stops at its terminal value and later ticks change nothing and fire no strobe. The terminal value is the reload value in up mode, and 0 in down mode and in up/down mode after a descending step.
- R7: A falling edge on `restart_i` (high one cycle, low the next) loads the start value in the following clock. The start value is the reload value with `down_o`=1 in down mode, and 0 with `down_o`=0 otherwise. The restart also clears the prescaler phase and the one-shot stop. It fires no strobe and acts whether or not the timer is enabled.
- R8: `zero_evt_o` and `reload_evt_o` are high for exactly the cycle in which a step has just made `count_o` equal to 0 or to the reload value.
- R9: `timeout_evt_o` is high for the cycle after a step that lands on the reload value while counting up, or on 0 while counting down.
- R10: `cmpx_evt_o` and `cmpy_evt_o` are high for the cycle after a step that lands on `cmp_x_i` or `cmp_y_i`. `down_o` in that cycle gives the direction of the step.
- R11: Mode code 2'b00 is idle. The count and direction hold and no strobe fires, although the prescaler keeps running.
- R12: After reset, `count_o` is 0, `down_o` is 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer enable |
| restart_i | input | 1 | Restart control, acts on its falling edge |
| periodic_i | input | 1 | 1 = periodic, 0 = one-shot |
| mode_i | input | 2 | 10 up, 01 down, 11 up/down, 00 idle |
| reload_i | input | W | Terminal count (up) or start count (down) |
| presc_i | input | W | Prescaler divide value minus one |
| cmp_x_i | input | W | Compare value X |
| cmp_y_i | input | W | Compare value Y |
| count_o | output | W | Current count |
| down_o | output | 1 | Direction of the last step (1 = descending) |
| zero_evt_o | output | 1 | Step landed on 0 |
| reload_evt_o | output | 1 | Step landed on the reload value |
| timeout_evt_o | output | 1 | Terminal count reached in the current direction |
| cmpx_evt_o | output | 1 | Step landed on compare X |
| cmpy_evt_o | output | 1 | Step landed on compare Y |

## Verification
The hardest states to reach are the ones where the events disagree with the current direction and one-shot state. Examples are a restart arriving in the middle of a prescaler period, a stopped one-shot counter receiving ticks, the up/down turnaround with a reload value of 0, and a restart while disabled. The stimulus runs through the modes in sequence and inserts restart pulses at chosen phases, including one in mode idle and one with enable low. A cycle-level reference model predicts the count, the direction and all five strobes for every clock, and a monitor compares them against the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_DOWN = 2'b01,
    MODE_UP   = 2'b10,
    MODE_UPDN = 2'b11
  } mode_e;

  localparam int unsigned EVT_ZERO   = 0;
  localparam int unsigned EVT_RELOAD = 1;
  localparam int unsigned EVT_CMPX   = 2;
  localparam int unsigned EVT_CMPY   = 3;
  localparam int unsigned NUM_CMP    = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] phase_q;
  logic         wrap;

  // >= keeps a lowered limit from running the phase through a full wrap
  assign wrap   = (phase_q >= limit_i);
  assign tick_o = en_i & ~clr_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= '0;
    else if (clr_i || !en_i)  phase_q <= '0;
    else if (wrap)            phase_q <= '0;
    else                      phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  mode_e        mode_i,
  input  logic         periodic_i,
  input  logic [W-1:0] count_i,
  input  logic         down_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         down_o,
  output logic         stop_o,
  output logic         active_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic at_top, at_zero, rl_zero;

  assign at_top  = (count_i >= reload_i);
  assign at_zero = (count_i == '0);
  assign rl_zero = (reload_i == '0);

  always_comb begin
    count_o  = count_i;
    down_o   = down_i;
    active_o = 1'b1;
    unique case (mode_i)
      MODE_UP: begin
        down_o  = 1'b0;
        count_o = at_top ? '0 : count_i + ONE;
      end
      MODE_DOWN: begin
        down_o  = 1'b1;
        count_o = at_zero ? reload_i : count_i - ONE;
      end
      MODE_UPDN: begin
        if (!down_i) begin
          if (at_top) begin
            down_o  = 1'b1;
            count_o = at_zero ? '0 : count_i - ONE;
          end else begin
            down_o  = 1'b0;
            count_o = count_i + ONE;
          end
        end else begin
          if (at_zero) begin
            down_o  = 1'b0;
            count_o = rl_zero ? '0 : ONE;
          end else begin
            down_o  = 1'b1;
            count_o = count_i - ONE;
          end
        end
      end
      default: active_o = 1'b0;
    endcase
  end

  always_comb begin
    stop_o = 1'b0;
    if (!periodic_i) begin
      unique case (mode_i)
        MODE_UP:   stop_o = (count_o == reload_i);
        MODE_DOWN,
        MODE_UPDN: stop_o = (count_o == '0) & down_o;
        default:   stop_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 4
) (
  input  logic [W-1:0]        value_i,
  input  logic [N-1:0][W-1:0] target_i,
  output logic [N-1:0]        hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = (value_i == target_i[g]);
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         restart_i,
  input  logic         periodic_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] reload_i,
  input  logic [W-1:0] presc_i,
  input  logic [W-1:0] cmp_x_i,
  input  logic [W-1:0] cmp_y_i,
  output logic [W-1:0] count_o,
  output logic         down_o,
  output logic         zero_evt_o,
  output logic         reload_evt_o,
  output logic         timeout_evt_o,
  output logic         cmpx_evt_o,
  output logic         cmpy_evt_o
);
  mode_e mode;
  assign mode = mode_e'(mode_i);

  logic         restart_q, restart_fall;
  logic         tick, move;
  logic [W-1:0] cnt_q, nxt_cnt, start_cnt;
  logic         down_q, done_q, nxt_down, nxt_stop, step_ok, start_down;
  logic [NUM_CMP-1:0][W-1:0] targets;
  logic [NUM_CMP-1:0]        hits;
  logic         timeout;
  logic [NUM_CMP:0]          evt_q;

  assign restart_fall = restart_q & ~restart_i;

  tmr_prescaler #(.W(W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .clr_i  (restart_fall),
    .limit_i(presc_i),
    .tick_o (tick)
  );

  tmr_step #(.W(W)) u_step (
    .mode_i    (mode),
    .periodic_i(periodic_i),
    .count_i   (cnt_q),
    .down_i    (down_q),
    .reload_i  (reload_i),
    .count_o   (nxt_cnt),
    .down_o    (nxt_down),
    .stop_o    (nxt_stop),
    .active_o  (step_ok)
  );

  always_comb begin
    targets             = '0;
    targets[EVT_ZERO]   = '0;
    targets[EVT_RELOAD] = reload_i;
    targets[EVT_CMPX]   = cmp_x_i;
    targets[EVT_CMPY]   = cmp_y_i;
  end

  tmr_match #(.W(W), .N(NUM_CMP)) u_match (
    .value_i (nxt_cnt),
    .target_i(targets),
    .hit_o   (hits)
  );

  assign timeout    = nxt_down ? hits[EVT_ZERO] : hits[EVT_RELOAD];
  assign move       = tick & ~done_q & step_ok;
  assign start_down = (mode == MODE_DOWN);
  assign start_cnt  = start_down ? reload_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) restart_q <= 1'b0;
    else         restart_q <= restart_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      done_q <= 1'b0;
      evt_q  <= '0;
    end else if (restart_fall) begin
      cnt_q  <= start_cnt;
      down_q <= start_down;
      done_q <= 1'b0;
      evt_q  <= '0;
    end else if (move) begin
      cnt_q  <= nxt_cnt;
      down_q <= nxt_down;
      done_q <= nxt_stop;
      evt_q  <= {timeout, hits};
    end else begin
      evt_q  <= '0;
    end
  end

  assign count_o       = cnt_q;
  assign down_o        = down_q;
  assign zero_evt_o    = evt_q[EVT_ZERO];
  assign reload_evt_o  = evt_q[EVT_RELOAD];
  assign cmpx_evt_o    = evt_q[EVT_CMPX];
  assign cmpy_evt_o    = evt_q[EVT_CMPY];
  assign timeout_evt_o = evt_q[NUM_CMP];
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         restart_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] reload_i,
  input logic [W-1:0] cmp_x_i,
  input logic [W-1:0] cmp_y_i,
  input logic [W-1:0] count_o,
  input logic         down_o,
  input logic         zero_evt_o,
  input logic         reload_evt_o,
  input logic         timeout_evt_o,
  input logic         cmpx_evt_o,
  input logic         cmpy_evt_o
);
  logic rs_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 1'b0;
    else         rs_q <= restart_i;
  end

  AST_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt_o |-> (count_o == '0)); // R8
  AST_RELOAD_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_evt_o |-> (count_o == $past(reload_i))); // R8
  AST_TIMEOUT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_evt_o |-> (down_o ? zero_evt_o : reload_evt_o)); // R9
  AST_CMPX_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpx_evt_o |-> (count_o == $past(cmp_x_i))); // R10
  AST_CMPY_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpy_evt_o |-> (count_o == $past(cmp_y_i))); // R10
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i && !rs_q) |=> ($stable(count_o) && $stable(down_o)
      && !zero_evt_o && !cmpx_evt_o && !cmpy_evt_o)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !restart_i && !rs_q) |=> ($stable(count_o) && !timeout_evt_o)); // R11
endmodule

bind tmr_core tmr_core_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .restart_i    (restart_i),
  .mode_i       (mode_i),
  .reload_i     (reload_i),
  .cmp_x_i      (cmp_x_i),
  .cmp_y_i      (cmp_y_i),
  .count_o      (count_o),
  .down_o       (down_o),
  .zero_evt_o   (zero_evt_o),
  .reload_evt_o (reload_evt_o),
  .timeout_evt_o(timeout_evt_o),
  .cmpx_evt_o   (cmpx_evt_o),
  .cmpy_evt_o   (cmpy_evt_o)
);

// File: tb/tmr_core_test.sv
module tmr_core_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0, restart_i = 1'b0, periodic_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [W-1:0] reload_i = '0, presc_i = '0, cmp_x_i = '0, cmp_y_i = '0;
  logic [W-1:0] count_o;
  logic         down_o, zero_evt_o, reload_evt_o, timeout_evt_o, cmpx_evt_o, cmpy_evt_o;

  int n_chk = 0;
  int n_err = 0;
  string cur_tag = "R12";

  always #4 clk = ~clk;

  tmr_core #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .restart_i(restart_i),
    .periodic_i(periodic_i), .mode_i(mode_i), .reload_i(reload_i),
    .presc_i(presc_i), .cmp_x_i(cmp_x_i), .cmp_y_i(cmp_y_i),
    .count_o(count_o), .down_o(down_o), .zero_evt_o(zero_evt_o),
    .reload_evt_o(reload_evt_o), .timeout_evt_o(timeout_evt_o),
    .cmpx_evt_o(cmpx_evt_o), .cmpy_evt_o(cmpy_evt_o)
  );

  typedef struct packed {
    logic [W-1:0] cnt;
    logic         dn;
    logic [4:0]   ev; // {timeout, cmpy, cmpx, reload, zero}
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  // reference model state
  logic [W-1:0] m_cnt = '0, m_pc = '0, nc;
  logic         m_dn = 1'b0, m_done = 1'b0, m_rq = 1'b0, nd, fall;
  logic [4:0]   ev;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt = '0; m_pc = '0; m_dn = 1'b0; m_done = 1'b0; m_rq = 1'b0;
    end else begin
      ev   = '0;
      fall = m_rq & ~restart_i;
      m_rq = restart_i;
      nc   = m_cnt;
      nd   = m_dn;
      if (fall) begin
        m_cnt  = (mode_i == 2'b01) ? reload_i : '0;
        m_dn   = (mode_i == 2'b01);
        m_done = 1'b0;
        m_pc   = '0;
      end else if (!en_i) begin
        m_pc = '0;
      end else if (m_pc < presc_i) begin
        m_pc = m_pc + 1;
      end else begin
        m_pc = '0;
        if (!m_done && mode_i != 2'b00) begin
          case (mode_i)
            2'b10: begin nd = 1'b0; nc = (m_cnt >= reload_i) ? '0 : m_cnt + 1; end
            2'b01: begin nd = 1'b1; nc = (m_cnt == 0) ? reload_i : m_cnt - 1; end
            default: begin
              if (!m_dn) begin
                if (m_cnt >= reload_i) begin nd = 1'b1; nc = (m_cnt == 0) ? '0 : m_cnt - 1; end
                else begin nd = 1'b0; nc = m_cnt + 1; end
              end else begin
                if (m_cnt == 0) begin nd = 1'b0; nc = (reload_i == 0) ? '0 : 1; end
                else begin nd = 1'b1; nc = m_cnt - 1; end
              end
            end
          endcase
          ev[0] = (nc == 0);
          ev[1] = (nc == reload_i);
          ev[2] = (nc == cmp_x_i);
          ev[3] = (nc == cmp_y_i);
          ev[4] = nd ? (nc == 0) : (nc == reload_i);
          if (!periodic_i)
            m_done = (mode_i == 2'b10) ? (nc == reload_i) : ((nc == 0) && nd);
          m_cnt = nc;
          m_dn  = nd;
        end
      end
      exp_q.push_back({m_cnt, m_dn, ev});
      tag_q.push_back(cur_tag);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {count_o, down_o, timeout_evt_o, cmpy_evt_o, cmpx_evt_o, reload_evt_o, zero_evt_o};
      n_chk++;
      if (a !== e) begin
        n_err++;
        $display("FAIL %s: count=%0d down=%0b ev=%b expected count=%0d down=%0b ev=%b",
                 t, a.cnt, a.dn, a.ev, e.cnt, e.dn, e.ev);
      end
    end
  end

  task automatic run(input int n, input string tag);
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_restart(input string tag);
    restart_i = 1'b1;
    run(1, tag);
    restart_i = 1'b0;
    run(1, tag);
  endtask

  task automatic check_reset(input logic [W-1:0] c, input logic d, input logic [4:0] e);
    n_chk++;
    if ({c, d, e} !== {{W{1'b0}}, 1'b0, 5'b0}) begin
      n_err++;
      $display("FAIL R12: count=%0d down=%0b ev=%b expected count=0 down=0 ev=00000", c, d, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset(count_o, down_o,
                {timeout_evt_o, cmpy_evt_o, cmpx_evt_o, reload_evt_o, zero_evt_o});
    rst_ni = 1'b1;
    run(1, "R12");
    check_reset(count_o, down_o,
                {timeout_evt_o, cmpy_evt_o, cmpx_evt_o, reload_evt_o, zero_evt_o});

    // up, periodic
    mode_i = 2'b10; periodic_i = 1'b1; reload_i = 5; cmp_x_i = 2; cmp_y_i = 4; en_i = 1'b1;
    run(20, "R3/R8/R9/R10");
    // prescaler ratios
    presc_i = 3;  run(40, "R1");
    presc_i = 1;  run(12, "R1");
    presc_i = 0;
    // disabled
    en_i = 1'b0;  run(10, "R2");
    en_i = 1'b1;
    // down, periodic
    mode_i = 2'b01; reload_i = 6; cmp_x_i = 3; cmp_y_i = 6;
    pulse_restart("R7");
    run(20, "R4/R8/R9/R10");
    // up/down
    mode_i = 2'b11; reload_i = 4; cmp_x_i = 2; cmp_y_i = 4;
    pulse_restart("R7");
    run(25, "R5/R9/R10");
    // one-shot variants
    periodic_i = 1'b0; mode_i = 2'b10; reload_i = 3;
    pulse_restart("R7");
    run(12, "R6");
    pulse_restart("R7");
    run(8, "R6");
    mode_i = 2'b01;
    pulse_restart("R7");
    run(12, "R6");
    mode_i = 2'b11;
    pulse_restart("R7");
    run(16, "R6");
    // restart mid-prescale and while disabled
    periodic_i = 1'b1; mode_i = 2'b10; presc_i = 4; reload_i = 9;
    run(7, "R1");
    pulse_restart("R7");
    run(15, "R7/R1");
    en_i = 1'b0; mode_i = 2'b01;
    pulse_restart("R7");
    run(5, "R7/R2");
    en_i = 1'b1; presc_i = 0;
    // idle mode
    mode_i = 2'b00; run(10, "R11");
    pulse_restart("R11/R7");
    run(5, "R11");
    // reload of zero in each mode
    reload_i = 0; cmp_x_i = 0;
    mode_i = 2'b10; pulse_restart("R7"); run(5, "R3/R8");
    mode_i = 2'b11; pulse_restart("R7"); run(6, "R5/R9");
    mode_i = 2'b01; pulse_restart("R7"); run(4, "R4/R8");
    // mode change mid-run
    reload_i = 7; cmp_x_i = 5; cmp_y_i = 1; mode_i = 2'b10;
    run(6, "R3/R10");
    mode_i = 2'b11; run(18, "R5/R10");
    run(2, "R5");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule